// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous fast-page DRAM refreshed and brings it out of power-up. After reset it holds off for a programmable pause. It then runs a fixed number of warm-up refresh cycles and raises a done flag. From then on it schedules one refresh per interval, so that every row is refreshed within the retention period. With the default values this is 512 rows in 8 ms, one refresh every 15.6 us at 200 MHz.

The block asks the access controller for the memory through a request line. While the controller answers with a grant, the block drives the row strobe, both column strobes, the write strobe and the address pins directly. Each refresh uses either of two forms, chosen per refresh by a mode input. In the column-first form the column strobes fall ahead of the row strobe, and the DRAM supplies the row from its own counter. In the row-only form the column strobes stay high and the block drives its own 9-bit row counter onto the address pins. If refresh intervals expire while the grant is withheld, the missed refreshes are counted up to a limit and issued back to back once the grant returns.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset, req_o stays low and all strobes stay high until exactly INIT_CYCLES rising clock edges have passed. req_o goes high after the INIT_CYCLES-th edge.
- R2: After the pause, WARMUP refresh cycles are issued. init_done_o rises at the end of the last of them, stays low before that, and stays high until the next reset.
- R3: When ras_only_i is 0 at the start of a refresh (column-first form), both column strobes are low for T_CSR cycles before the row strobe falls. They stay low for the first T_CHR cycles of the row-strobe low time and then return high. we_n_o is high and addr_o is 0 while the row strobe is low.
- R4: When ras_only_i is 1 at the start of a refresh (row-only form), both column strobes stay high throughout. addr_o carries the row counter while the row strobe is low. The row counter is 0 after reset, advances by one after each row-only refresh, and wraps from 511 to 0. Column-first refreshes leave it unchanged.
- R5: Between two row-strobe pulses the row strobe stays high for at least T_RP cycles, and both column strobes are high when the row strobe rises.
- R6: Every row-strobe low pulse lasts exactly T_RAS cycles.
- R7: Once init_done_o is high, one refresh falls due every REFI_CYCLES cycles. With grant_i held high and the mode unchanged, successive row-strobe falls are exactly REFI_CYCLES cycles apart.
- R8: Refreshes that fall due while grant_i is low are counted, saturating at OWED_MAX. When the grant returns, exactly min(missed, OWED_MAX) refreshes are issued back to back. In column-first form, the row-strobe falls of back-to-back refreshes are T_CSR+T_RAS+T_RP+1 cycles apart.
- R9: req_o is high only while a refresh is due, a warm-up refresh is pending or a refresh is in progress. A refresh starts only on an edge where grant_i and req_o are both high. Strobes are never active while req_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_only_i | input | 1 | Refresh form: 1 row-only with own address, 0 column-first |
| grant_i | input | 1 | Memory bus granted to this block by the access controller |
| req_o | output | 1 | Request for the memory bus |
| ras_n_o | output | 1 | Row strobe, active low |
| ucas_n_o | output | 1 | Upper column strobe, active low |
| lcas_n_o | output | 1 | Lower column strobe, active low |
| we_n_o | output | 1 | Write strobe, held high |
| addr_o | output | ROW_W | Row address for row-only refresh |
| init_done_o | output | 1 | Power-up sequence complete |

## Verification
The bench runs a small configuration through the pause, the warm-up, steady refresh in both forms, and withheld-grant windows of one, two, three and five intervals. A miscounted pause or warm-up shows as a req_o or init_done_o edge one cycle off. A timer that restarts at the wrong point breaks the exact fall spacing. An owed counter that does not saturate, or that drops refreshes, gives the wrong number of back-to-back pulses after the grant returns. The row-only run continues past 511 so that a row counter that fails to wrap, or that also advances on column-first refreshes, puts a wrong address on the pins. The strobe-shape checks catch column strobes that release too early or too late around the row-strobe pulse.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CAS_SETUP,
    ST_RAS_LOW,
    ST_PRECHG
  } seq_state_e;
endpackage

// File: rtl/power_up_ctrl.sv
module power_up_ctrl #(
  parameter int INIT_CYCLES = 40000,
  parameter int WARMUP      = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  output logic warm_pending_o,
  output logic init_done_o
);
  localparam int PW = $clog2(INIT_CYCLES + 1);
  localparam int WW = $clog2(WARMUP + 1);

  logic [PW-1:0] pause_cnt_q;
  logic          pause_done_q;
  logic [WW-1:0] warm_left_q;
  logic          init_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pause_cnt_q  <= '0;
      pause_done_q <= 1'b0;
    end else if (!pause_done_q) begin
      if (pause_cnt_q == PW'(INIT_CYCLES - 1)) pause_done_q <= 1'b1;
      else pause_cnt_q <= pause_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_left_q <= WW'(WARMUP);
      init_done_q <= 1'b0;
    end else if (done_i && warm_left_q != '0) begin
      warm_left_q <= warm_left_q - 1'b1;
      if (warm_left_q == WW'(1)) init_done_q <= 1'b1;
    end
  end

  assign warm_pending_o = pause_done_q && (warm_left_q != '0);
  assign init_done_o    = init_done_q;
endmodule

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int REFI_CYCLES = 3120,
  parameter int OWED_MAX    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic done_i,
  output logic owed_o
);
  localparam int CW = $clog2(REFI_CYCLES);
  localparam int OW = $clog2(OWED_MAX + 1);

  logic [CW-1:0] cnt_q;
  logic [OW-1:0] owed_q;
  logic          tick;

  assign tick = run_i && (cnt_q == CW'(REFI_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end

  // saturating debt counter: a tick and a completion in one cycle cancel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owed_q <= '0;
    else begin
      unique case ({tick, done_i})
        2'b10: if (owed_q != OW'(OWED_MAX)) owed_q <= owed_q + 1'b1;
        2'b01: if (owed_q != '0) owed_q <= owed_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign owed_o = (owed_q != '0);
endmodule

// File: rtl/row_addr_counter.sv
module row_addr_counter #(
  parameter int ROW_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  // wraps naturally at 2**ROW_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (adv_i) row_q <= row_q + 1'b1;
  end

  assign row_o = row_q;
endmodule

// File: rtl/refresh_pulse_fsm.sv
module refresh_pulse_fsm
  import dram_refresh_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int T_CSR = 2,
  parameter int T_CHR = 3,
  parameter int T_RAS = 12,
  parameter int T_RP  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             need_i,
  input  logic             grant_i,
  input  logic             ras_only_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             done_row_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic [ROW_W-1:0] addr_o
);
  localparam int T_A   = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int T_MAX = (T_A > T_RP) ? T_A : T_RP;
  localparam int CW    = $clog2(T_MAX + 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          row_mode_q;
  logic          start;

  assign start = (state_q == ST_IDLE) && need_i && grant_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start) state_d = ras_only_i ? ST_RAS_LOW : ST_CAS_SETUP;
      end
      ST_CAS_SETUP: if (cnt_q == CW'(T_CSR - 1)) begin
        state_d = ST_RAS_LOW;
        cnt_d   = '0;
      end
      ST_RAS_LOW: if (cnt_q == CW'(T_RAS - 1)) begin
        state_d = ST_PRECHG;
        cnt_d   = '0;
      end
      ST_PRECHG: if (cnt_q == CW'(T_RP - 1)) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      row_mode_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (start) row_mode_q <= ras_only_i;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_PRECHG) && (cnt_q == CW'(T_RP - 1));
  assign done_row_o = done_o && row_mode_q;
  assign ras_n_o    = (state_q != ST_RAS_LOW);
  assign cas_n_o    = !((state_q == ST_CAS_SETUP) ||
                        (state_q == ST_RAS_LOW && !row_mode_q && cnt_q < CW'(T_CHR)));
  assign addr_o     = (state_q == ST_RAS_LOW && row_mode_q) ? row_i : '0;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int INIT_CYCLES = 40000,
  parameter int REFI_CYCLES = 3120,
  parameter int WARMUP      = 8,
  parameter int OWED_MAX    = 4,
  parameter int ROW_W       = 9,
  parameter int T_CSR       = 2,
  parameter int T_CHR       = 3,
  parameter int T_RAS       = 12,
  parameter int T_RP        = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_only_i,
  input  logic             grant_i,
  output logic             req_o,
  output logic             ras_n_o,
  output logic             ucas_n_o,
  output logic             lcas_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             init_done_o
);
  logic             done, done_row, busy;
  logic             warm_pending, init_done, owed, need;
  logic             cas_n;
  logic [ROW_W-1:0] row;

  power_up_ctrl #(.INIT_CYCLES(INIT_CYCLES), .WARMUP(WARMUP)) u_pwr (
    .clk_i, .rst_ni, .done_i(done),
    .warm_pending_o(warm_pending), .init_done_o(init_done)
  );

  refresh_interval_timer #(.REFI_CYCLES(REFI_CYCLES), .OWED_MAX(OWED_MAX)) u_tmr (
    .clk_i, .rst_ni, .run_i(init_done), .done_i(done && init_done),
    .owed_o(owed)
  );

  row_addr_counter #(.ROW_W(ROW_W)) u_row (
    .clk_i, .rst_ni, .adv_i(done_row), .row_o(row)
  );

  assign need = warm_pending || owed;

  refresh_pulse_fsm #(
    .ROW_W(ROW_W), .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)
  ) u_fsm (
    .clk_i, .rst_ni, .need_i(need), .grant_i, .ras_only_i, .row_i(row),
    .busy_o(busy), .done_o(done), .done_row_o(done_row),
    .ras_n_o, .cas_n_o(cas_n), .addr_o
  );

  assign req_o       = need || busy;
  assign ucas_n_o    = cas_n;
  assign lcas_n_o    = cas_n;
  assign we_n_o      = 1'b1;
  assign init_done_o = init_done;
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int T_RAS = 12,
  parameter int T_RP  = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_o,
  input logic ras_n_o,
  input logic ucas_n_o,
  input logic lcas_n_o,
  input logic init_done_o
);
  logic [15:0] lo_run_q, hi_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run_q <= '0;
      hi_run_q <= '1;
    end else begin
      lo_run_q <= ras_n_o ? '0 : ((lo_run_q == '1) ? lo_run_q : lo_run_q + 1'b1);
      hi_run_q <= !ras_n_o ? '0 : ((hi_run_q == '1) ? hi_run_q : hi_run_q + 1'b1);
    end
  end

  assert_ras_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (lo_run_q == 16'(T_RAS)));

  assert_precharge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (hi_run_q >= 16'(T_RP)));

  assert_cas_high_at_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (ucas_n_o && lcas_n_o));

  assert_cas_leads_ras_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !ucas_n_o) |-> $past(!ucas_n_o && !lcas_n_o));

  assert_strobe_needs_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !ucas_n_o || !lcas_n_o) |-> req_o);

  assert_init_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.T_RAS(T_RAS), .T_RP(T_RP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_o(req_o), .ras_n_o(ras_n_o),
  .ucas_n_o(ucas_n_o), .lcas_n_o(lcas_n_o), .init_done_o(init_done_o)
);

// File: tb/dram_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb_top;
  localparam int INIT  = 20;
  localparam int REFI  = 40;
  localparam int WARM  = 8;
  localparam int OWED  = 3;
  localparam int ROW_W = 9;
  localparam int TCSR  = 1;
  localparam int TCHR  = 2;
  localparam int TRAS  = 3;
  localparam int TRP   = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ras_only_i = 1'b1;
  logic grant_i = 1'b0;
  logic req_o, ras_n_o, ucas_n_o, lcas_n_o, we_n_o, init_done_o;
  logic [ROW_W-1:0] addr_o;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(
    .INIT_CYCLES(INIT), .REFI_CYCLES(REFI), .WARMUP(WARM), .OWED_MAX(OWED),
    .ROW_W(ROW_W), .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP)
  ) dut_i (
    .clk_i(clk), .rst_ni, .ras_only_i, .grant_i, .req_o, .ras_n_o,
    .ucas_n_o, .lcas_n_o, .we_n_o, .addr_o, .init_done_o
  );

  int nchk = 0, nfail = 0;
  int fall_cnt = 0, cyc = 0, last_fall = 0, last_gap = 0;
  int ras_hi_run = 1000, ras_lo_run = 0, cas_lo_run = 0, cas_in_ras = 0;
  int exp_row = 0;
  bit prev_ras = 1'b1, steady = 1'b0, wrap_seen = 1'b0, finished = 1'b0;
  event fall_ev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  // cycle monitor: strobe shapes, addresses and spacing
  always @(negedge clk) begin
    if (rst_ni) begin
      cyc++;
      if (prev_ras && !ras_n_o) begin
        fall_cnt++;
        chk(ras_hi_run >= TRP, "R5 precharge", ras_hi_run, TRP);
        chk(ucas_n_o == lcas_n_o, "R3 strobe pair", ucas_n_o, lcas_n_o);
        if (!init_done_o) chk(fall_cnt <= WARM, "R2 warm-up count", fall_cnt, WARM);
        if (ras_only_i) begin
          chk(ucas_n_o && lcas_n_o, "R4 cas high", ucas_n_o, 1);
          chk(addr_o == ROW_W'(exp_row), "R4 row addr", addr_o, exp_row);
          if (exp_row == 511) wrap_seen = 1'b1;
          exp_row = (exp_row + 1) % 512;
        end else begin
          chk(cas_lo_run == TCSR, "R3 cas setup", cas_lo_run, TCSR);
          chk(addr_o == '0, "R3 addr zero", addr_o, 0);
          chk(we_n_o == 1'b1, "R3 we high", we_n_o, 1);
        end
        if (steady) chk(cyc - last_fall == REFI, "R7 interval", cyc - last_fall, REFI);
        last_gap   = cyc - last_fall;
        last_fall  = cyc;
        ras_lo_run = 1;
        cas_in_ras = !ucas_n_o ? 1 : 0;
        -> fall_ev;
      end else if (!ras_n_o) begin
        ras_lo_run++;
        if (!ucas_n_o) cas_in_ras++;
      end
      if (!prev_ras && ras_n_o) begin
        chk(ras_lo_run == TRAS, "R6 ras width", ras_lo_run, TRAS);
        chk(cas_in_ras == (ras_only_i ? 0 : TCHR), "R3/R4 cas hold", cas_in_ras,
            ras_only_i ? 0 : TCHR);
        chk(ucas_n_o && lcas_n_o, "R5 cas high at rise", ucas_n_o, 1);
      end
      ras_hi_run = ras_n_o ? ras_hi_run + 1 : 0;
      cas_lo_run = !ucas_n_o ? cas_lo_run + 1 : 0;
      prev_ras   = ras_n_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    int ks[4] = '{1, 2, 3, 5};
    repeat (3) @(negedge clk);
    // reset state
    chk(req_o == 0, "R1 reset req", req_o, 0);
    chk(ras_n_o && ucas_n_o && lcas_n_o, "R1 reset strobes", ras_n_o, 1);
    chk(init_done_o == 0, "R2 reset init_done", init_done_o, 0);
    rst_ni = 1'b1;

    // R1: pause length, with grant still withheld
    n = 0;
    do begin @(negedge clk); n++; end while (!req_o && n < 1000);
    chk(n == INIT, "R1 pause length", n, INIT);
    chk(fall_cnt == 0, "R1 no strobe in pause", fall_cnt, 0);
    repeat (5) @(negedge clk);
    chk(fall_cnt == 0, "R9 no start without grant", fall_cnt, 0);
    chk(req_o == 1, "R9 req held", req_o, 1);
    grant_i = 1'b1;

    // R2: warm-up in row-only form
    n = 0;
    while (!init_done_o && n < 1000) begin @(negedge clk); n++; end
    chk(fall_cnt == WARM, "R2 init after warm-up", fall_cnt, WARM);
    chk(req_o == 0, "R9 req drops after warm-up", req_o, 0);

    // R7 steady row-only
    @(fall_ev); steady = 1'b1;
    repeat (3) @(fall_ev);
    steady = 1'b0;
    repeat (15) @(negedge clk);
    chk(req_o == 0 && ras_n_o, "R9 idle mid-interval", req_o, 0);

    // column-first form
    ras_only_i = 1'b0;
    @(fall_ev); steady = 1'b1;
    repeat (3) @(fall_ev);
    steady = 1'b0;

    // R8 owed refreshes
    foreach (ks[i]) begin
      int n0, expn;
      @(fall_ev);
      grant_i = 1'b0;
      n0 = fall_cnt;
      repeat (ks[i] * REFI + 5) @(negedge clk);
      chk(fall_cnt == n0, "R9 no refresh while ungranted", fall_cnt - n0, 0);
      grant_i = 1'b1;
      repeat (25) @(negedge clk);
      expn = (ks[i] < OWED) ? ks[i] : OWED;
      chk(fall_cnt - n0 == expn, "R8 owed count", fall_cnt - n0, expn);
      if (expn > 1)
        chk(last_gap == TCSR + TRAS + TRP + 1, "R8 back-to-back", last_gap,
            TCSR + TRAS + TRP + 1);
      chk(req_o == 0, "R9 req clear after catch-up", req_o, 0);
    end

    // R4 row wrap in row-only form
    @(fall_ev);
    repeat (10) @(negedge clk);
    ras_only_i = 1'b1;
    while (!wrap_seen) @(fall_ev);
    repeat (2) @(fall_ev);
    chk(exp_row >= 1 && exp_row < 8, "R4 wrapped", exp_row, 2);
    chk(init_done_o == 1, "R2 init sticky", init_done_o, 1);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule